// File: doc/BRIEF.md
# Glitch-free synchronized clock stop gate

This block sits after a clock divider and turns a group of copies of that clock on and off in response to an asynchronous, active-low stop request. The request passes through a two-flop synchronizer. A small run controller then decides when the group may stop or restart. One gate flop per output, clocked on the falling edge, applies the decision. Because the gate changes only while the source clock is low, a gated output always parks low and always restarts with a complete high phase.

The group also carries one free-running output that the stop request never touches. Configuration registers supply a per-output enable mask and an enable bit for the free-running output. A cleared bit holds that output low. A minimum run length keeps a freshly restarted group running for a set number of high phases before a new stop can take effect. A registered `stopped_o` flag reports when the group is parked.

Top module: `clk_stop_gate`

## Requirements
- R1: While `rst` is high, every gated output and the free output are low and `stopped_o` is 1. After `rst` falls, the first high phase on any output comes at the second rising edge.
- R2: Suppose `stop_n` goes low before rising edge k and the minimum run length has already been met. The gated outputs then give their last high phase at edge k+2, and `stopped_o` reads 1 from edge k+2 onward. This is fewer than 4 periods after the request.
- R3: While the group is stopped, every gated output stays low and `stopped_o` stays 1 for as long as `stop_n` stays low.
- R4: Suppose `stop_n` returns high before rising edge k while the group is stopped. Then `stopped_o` clears at edge k+2 and the first gated high phase comes at edge k+3. Every high phase on every output spans the full high half of the source clock, and every output is low whenever the source clock is low.
- R5: After a start, the gated outputs deliver at least MIN_RUN high phases before a stop takes effect. A stop that arrives earlier is held back until that count is reached; it is not dropped.
- R6: The free output pulses with every source high phase while its enable is 1, whatever `stop_n` does.
- R7: `en_mask[i]` = 1 lets gated output i follow the group and 0 holds it low. The mask and `en_free` are sampled on each falling edge and govern the high phase that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock to be gated |
| rst | input | 1 | Synchronous active-high reset |
| stop_n | input | 1 | Asynchronous stop request, active low |
| en_mask | input | NUM_OUT | Per-output enable, 1 = enabled |
| en_free | input | 1 | Enable for the free-running output |
| gclk_o | output | NUM_OUT | Gated clock outputs |
| free_clk_o | output | 1 | Free-running clock output |
| stopped_o | output | 1 | 1 while the gated group is parked |

## Verification
The bench builds the block with NUM_OUT=3, MIN_RUN=6 and SYNC_STAGES=2. A minimum run of six phases lets a stop that arrives one cycle after a restart be deferred and then honoured inside a short window. With three outputs, a mask can enable a single output, a middle output, or both outer ones. The bench counts high phases per output in each window against hand-computed latencies. It also samples each high phase twice and each low phase once to catch runt or clipped pulses.

// File: rtl/csg_pkg.sv
package csg_pkg;
  typedef enum logic {
    GATE_STOPPED = 1'b0,
    GATE_RUNNING = 1'b1
  } gate_state_e;
endpackage

// File: rtl/csg_sync.sv
module csg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) sr_q <= '1;
    else     sr_q <= {sr_q[STAGES-2:0], din};
  end

  assign dout = sr_q[STAGES-1];
endmodule

// File: rtl/csg_runctl.sv
module csg_runctl
  import csg_pkg::*;
#(
  parameter int MIN_RUN = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic run_req,
  output logic run_o,
  output logic stopped_o
);
  localparam int CW = $clog2(MIN_RUN);
  localparam logic [CW-1:0] LIM = CW'(MIN_RUN - 1);

  gate_state_e     st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            stp_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (st_q == GATE_STOPPED) begin
      cnt_d = '0;
      if (run_req) st_d = GATE_RUNNING;
    end else begin
      if (cnt_q != LIM) cnt_d = cnt_q + 1'b1;
      if (!run_req && cnt_q == LIM) st_d = GATE_STOPPED;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= GATE_STOPPED;
      cnt_q <= '0;
      stp_q <= 1'b1;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      stp_q <= (st_d == GATE_STOPPED);
    end
  end

  assign run_o     = (st_q == GATE_RUNNING);
  assign stopped_o = stp_q;

  AST_MIN_RUN: assert property (@(posedge clk) disable iff (rst)
    ($past(st_q) == GATE_RUNNING && st_q == GATE_STOPPED) |-> ($past(cnt_q) == LIM)); // R5
  AST_OFF_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (st_q == GATE_RUNNING && !run_req && cnt_q == LIM) |=> (st_q == GATE_STOPPED)); // R2
  AST_ON_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (st_q == GATE_STOPPED && run_req) |=> (st_q == GATE_RUNNING && !stopped_o)); // R4
endmodule

// File: rtl/csg_gatecell.sv
module csg_gatecell (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic en,
  output logic gclk
);
  logic gate_q;

  always_ff @(negedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= run & en;
  end

  assign gclk = clk & gate_q;

  AST_MASK_LOW: assert property (@(negedge clk) disable iff (rst)
    !$past(en) |-> !gclk); // R7
  AST_RUN_LOW: assert property (@(negedge clk) disable iff (rst)
    !$past(run) |-> !gclk); // R3
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate
  import csg_pkg::*;
#(
  parameter int NUM_OUT     = 4,
  parameter int MIN_RUN     = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stop_n,
  input  logic [NUM_OUT-1:0] en_mask,
  input  logic               en_free,
  output logic [NUM_OUT-1:0] gclk_o,
  output logic               free_clk_o,
  output logic               stopped_o
);
  logic run_req;
  logic run;

  csg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (stop_n),
    .dout(run_req)
  );

  csg_runctl #(.MIN_RUN(MIN_RUN)) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .run_req  (run_req),
    .run_o    (run),
    .stopped_o(stopped_o)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_cell
    csg_gatecell u_cell (
      .clk (clk),
      .rst (rst),
      .run (run),
      .en  (en_mask[g]),
      .gclk(gclk_o[g])
    );
  end

  csg_gatecell u_free (
    .clk (clk),
    .rst (rst),
    .run (1'b1),
    .en  (en_free),
    .gclk(free_clk_o)
  );

  AST_STOPPED_QUIET: assert property (@(negedge clk) disable iff (rst)
    $past(stopped_o) |-> (gclk_o == '0)); // R3
  AST_FREE_RUNS: assert property (@(negedge clk) disable iff (rst)
    ($past(en_free) && !$past(rst)) |-> free_clk_o); // R6
endmodule

// File: tb/clk_stop_gate_test.sv
module clk_stop_gate_test;
  localparam int PERIOD = 10;
  localparam int NOUT   = 3;
  localparam int NVEC   = 9;

  typedef struct packed {
    logic            stop_n;
    logic [NOUT-1:0] mask;
    logic            free_en;
    logic [7:0]      ncyc;
    logic [7:0]      e0, e1, e2, ef;
    logic            est;
    logic [7:0]      req;
  } vec_t;

  // fields: stop_n, mask, free_en, cycles, pulses out0/out1/out2/free, stopped, requirement
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 3'b111, 1'b1, 8'd8, 8'd7, 8'd7, 8'd7, 8'd7, 1'b0, 8'd1}, // R1 start after reset
    '{1'b0, 3'b111, 1'b1, 8'd6, 8'd3, 8'd3, 8'd3, 8'd6, 1'b1, 8'd2}, // R2 stop latency
    '{1'b0, 3'b111, 1'b1, 8'd4, 8'd0, 8'd0, 8'd0, 8'd4, 1'b1, 8'd3}, // R3 held low
    '{1'b1, 3'b111, 1'b1, 8'd4, 8'd1, 8'd1, 8'd1, 8'd4, 1'b0, 8'd4}, // R4 restart latency
    '{1'b0, 3'b111, 1'b1, 8'd8, 8'd5, 8'd5, 8'd5, 8'd8, 1'b1, 8'd5}, // R5 deferred stop
    '{1'b1, 3'b101, 1'b1, 8'd8, 8'd5, 8'd0, 8'd5, 8'd8, 1'b0, 8'd7}, // R7 mask holds low
    '{1'b1, 3'b111, 1'b0, 8'd4, 8'd4, 8'd3, 8'd4, 8'd1, 1'b0, 8'd7}, // R7 sampled at fall
    '{1'b0, 3'b111, 1'b1, 8'd6, 8'd3, 8'd3, 8'd3, 8'd5, 1'b1, 8'd6}, // R6 free ignores stop
    '{1'b1, 3'b010, 1'b1, 8'd6, 8'd0, 8'd3, 8'd0, 8'd6, 1'b0, 8'd7}  // R7 single output
  };

  logic            clk = 1'b0;
  logic            rst;
  logic            stop_n;
  logic [NOUT-1:0] en_mask;
  logic            en_free;
  logic [NOUT-1:0] gclk_o;
  logic            free_clk_o;
  logic            stopped_o;

  int nchecks = 0;
  int nerr    = 0;
  int glitch  = 0;
  int pc [NOUT];
  int pf;

  always #(PERIOD/2) clk = ~clk;

  clk_stop_gate #(.NUM_OUT(NOUT), .MIN_RUN(6), .SYNC_STAGES(2)) uut (
    .clk       (clk),
    .rst       (rst),
    .stop_n    (stop_n),
    .en_mask   (en_mask),
    .en_free   (en_free),
    .gclk_o    (gclk_o),
    .free_clk_o(free_clk_o),
    .stopped_o (stopped_o)
  );

  task automatic clr();
    for (int i = 0; i < NOUT; i++) pc[i] = 0;
    pf = 0;
  endtask

  // one source period: two samples in the high phase, one in the low phase
  task automatic cyc();
    logic [NOUT-1:0] a, b;
    logic af, bf;
    @(posedge clk); #1;
    a = gclk_o; af = free_clk_o;
    #3;
    b = gclk_o; bf = free_clk_o;
    if (a !== b || af !== bf) glitch++;
    for (int i = 0; i < NOUT; i++) if (a[i]) pc[i]++;
    if (af) pf++;
    @(negedge clk); #1;
    if (gclk_o !== '0 || free_clk_o !== 1'b0) glitch++;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    #(PERIOD * 20000);
    nchecks++; nerr++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end

  initial begin
    rst = 1'b1; stop_n = 1'b1; en_mask = '1; en_free = 1'b1;
    clr();
    repeat (3) cyc();
    // R1: quiet and parked during reset
    for (int i = 0; i < NOUT; i++) chk($sformatf("R1 reset out%0d pulses", i), pc[i], 0);
    chk("R1 reset free pulses", pf, 0);
    chk("R1 reset stopped", int'(stopped_o), 1);
    rst = 1'b0;

    for (int v = 0; v < NVEC; v++) begin
      stop_n  = VECS[v].stop_n;
      en_mask = VECS[v].mask;
      en_free = VECS[v].free_en;
      clr();
      repeat (int'(VECS[v].ncyc)) cyc();
      chk($sformatf("R%0d vec%0d out0", VECS[v].req, v), pc[0], int'(VECS[v].e0));
      chk($sformatf("R%0d vec%0d out1", VECS[v].req, v), pc[1], int'(VECS[v].e1));
      chk($sformatf("R%0d vec%0d out2", VECS[v].req, v), pc[2], int'(VECS[v].e2));
      chk($sformatf("R%0d vec%0d free", VECS[v].req, v), pf, int'(VECS[v].ef));
      chk($sformatf("R%0d vec%0d stopped", VECS[v].req, v), int'(stopped_o), int'(VECS[v].est));
    end

    // R1: reset applied while running parks everything
    rst = 1'b1;
    cyc(); cyc();
    clr();
    cyc();
    chk("R1 mid-run reset out1 pulses", pc[1], 0);
    chk("R1 mid-run reset free pulses", pf, 0);
    chk("R1 mid-run reset stopped", int'(stopped_o), 1);
    rst = 1'b0;
    clr();
    cyc();
    chk("R1 no pulse at first edge after reset", pc[1] + pf, 0);
    cyc(); cyc();
    chk("R1 resume out1 pulses", pc[1], 2);
    chk("R1 resume free pulses", pf, 2);
    chk("R1 resume stopped", int'(stopped_o), 0);

    // R4: no runt or clipped phase anywhere in the run
    chk("R4 partial or low-phase pulses", glitch, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end
endmodule